// File: doc/BRIEF.md
# Descriptor Completion-Pointer Interrupt Unit

This block raises interrupt requests for a packet DMA engine with eight transmit and eight receive channels. Each channel keeps two pointers. The hardware pointer is loaded by the DMA side with the address of the last descriptor it has finished. The software pointer is loaded by a register-bus write with the address of the last descriptor that software has serviced. A channel is pending whenever the two differ.

Software acknowledges a channel by writing back the pointer value it read. The pending state therefore clears only when software has caught up with the hardware. A completion that lands after the read keeps the channel pending, so no completion can be lost. Raw pending state is readable per direction. Per-channel enables are changed through separate set and clear registers. Two outputs, one for transmit and one for receive, carry the OR of pending AND enabled across that direction's channels.

Register map (word addresses, 32-bit data): 0x00 transmit raw status, 0x01 receive raw status, 0x02/0x03 transmit enable set/clear, 0x04/0x05 receive enable set/clear, 0x10+n transmit channel n pointer, 0x20+n receive channel n pointer. In every status and enable register, bit n is channel n.

Top module: `cp_irq_unit`

## Requirements
- R1: There are eight transmit and eight receive channels, each with its own pointer register: transmit channel n at address 0x10+n, receive channel n at 0x20+n.
- R2: A pulse of tx_upd_vld (rx_upd_vld) loads the hardware pointer of channel tx_upd_chan (rx_upd_chan) with tx_upd_ptr (rx_upd_ptr). A read of a pointer address returns that channel's hardware pointer.
- R3: A bus write to a pointer address loads that channel's software pointer and leaves the value read back at that address unchanged.
- R4: A channel is pending in the cycle after any edge that leaves its two pointers unequal. It stays pending until a software write makes the pointers equal.
- R5: Address 0x00 (transmit) and 0x01 (receive) read the pending state of every channel, with bit n for channel n, whatever the enables are.
- R6: Writing to 0x02 (transmit) or 0x04 (receive) sets each enable bit whose data bit is 1 and leaves the bits written 0 unchanged. Reading either address returns the enables.
- R7: Writing to 0x03 (transmit) or 0x05 (receive) clears each enable bit whose data bit is 1 and leaves the bits written 0 unchanged. Reading either address returns the enables.
- R8: A hardware update and a software write to the same channel in the same cycle both take effect. The comparison in the following cycle uses both new values.
- R9: After reset all pointers and enables are zero, no channel is pending, and both request outputs are low.
- R10: tx_irq is the OR over transmit channels of pending AND enabled. rx_irq is the same for receive.
- R11: bus_rdata takes the addressed value in the cycle after bus_rd_en and holds it until the next read. Unmapped addresses read zero. Writes to status or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_upd_vld | input | 1 | Transmit hardware pointer update strobe |
| tx_upd_chan | input | 3 | Transmit channel being updated |
| tx_upd_ptr | input | 32 | New transmit hardware pointer |
| rx_upd_vld | input | 1 | Receive hardware pointer update strobe |
| rx_upd_chan | input | 3 | Receive channel being updated |
| rx_upd_ptr | input | 32 | New receive hardware pointer |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after bus_rd_en |
| tx_irq | output | 1 | Masked transmit interrupt request |
| rx_irq | output | 1 | Masked receive interrupt request |

## Verification
The assertions assume that each direction presents at most one hardware update per cycle and that only one bus write is in flight per cycle. A write therefore never hits the enable-set and enable-clear registers together. The random stimulus keeps to this: each cycle it draws at most one bus operation and at most one update per direction. It draws pointer values from a small range so that acknowledge writes often match and often miss, and directed cases cover the same-cycle update-and-acknowledge collision.

// File: rtl/cpirq_pkg.sv
package cpirq_pkg;
   localparam int unsigned ADDR_W    = 8;
   localparam int unsigned SLOT_W    = 4;
   localparam int unsigned MAX_CHANS = 1 << SLOT_W;

   localparam logic [ADDR_W-1:0] ADR_TX_RAW  = 8'h00;
   localparam logic [ADDR_W-1:0] ADR_RX_RAW  = 8'h01;
   localparam logic [ADDR_W-1:0] ADR_TX_MSET = 8'h02;
   localparam logic [ADDR_W-1:0] ADR_TX_MCLR = 8'h03;
   localparam logic [ADDR_W-1:0] ADR_RX_MSET = 8'h04;
   localparam logic [ADDR_W-1:0] ADR_RX_MCLR = 8'h05;
   localparam logic [ADDR_W-1:0] ADR_TX_PTR  = 8'h10;
   localparam logic [ADDR_W-1:0] ADR_RX_PTR  = 8'h20;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cpirq_chan.sv
module cpirq_chan #(
   parameter int unsigned PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_we,
   input  logic [PTR_W-1:0] hw_data,
   input  logic             sw_we,
   input  logic [PTR_W-1:0] sw_data,
   output logic [PTR_W-1:0] hw_ptr,
   output logic             pending
);
   logic [PTR_W-1:0] hw_ptr_q;
   logic [PTR_W-1:0] sw_ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hw_ptr_q <= '0;
         sw_ptr_q <= '0;
      end else begin
         if (hw_we) hw_ptr_q <= hw_data;
         if (sw_we) sw_ptr_q <= sw_data;
      end
   end

   assign hw_ptr  = hw_ptr_q;
   assign pending = (hw_ptr_q != sw_ptr_q);

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !hw_we && sw_data == hw_ptr_q) |=> !pending); // R4
   AST_UPD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_we && !sw_we && hw_data != sw_ptr_q) |=> pending); // R4
   AST_BOTH_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_we && sw_we && hw_data == sw_data) |=> !pending); // R8
   AST_HW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_we |=> $stable(hw_ptr)); // R3
endmodule

// File: rtl/cpirq_bank.sv
module cpirq_bank
   import cpirq_pkg::*;
#(
   parameter int unsigned       NUM     = 8,
   parameter int unsigned       PTR_W   = 32,
   parameter logic [ADDR_W-1:0] A_RAW   = 8'h00,
   parameter logic [ADDR_W-1:0] A_MSET  = 8'h02,
   parameter logic [ADDR_W-1:0] A_MCLR  = 8'h03,
   parameter logic [ADDR_W-1:0] A_PTR   = 8'h10,
   localparam int unsigned      IDX_W   = idx_width(NUM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_vld,
   input  logic [IDX_W-1:0]  upd_chan,
   input  logic [PTR_W-1:0]  upd_ptr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PTR_W-1:0]  wdata,
   output logic [NUM-1:0]    raw,
   output logic [NUM-1:0]    mask,
   output logic              irq,
   output logic [PTR_W-1:0]  rd_data
);
   if (NUM < 1 || NUM > MAX_CHANS) begin : g_bad_num
      $error("cpirq_bank: NUM must be 1..%0d", MAX_CHANS);
   end
   if (PTR_W < NUM) begin : g_bad_width
      $error("cpirq_bank: PTR_W must cover NUM status bits");
   end

   logic hit_raw, hit_mset, hit_mclr, hit_ptr;
   logic [SLOT_W-1:0] slot;
   logic [NUM-1:0][PTR_W-1:0] hw_ptrs;
   logic [NUM-1:0] mask_q;

   assign slot     = addr[SLOT_W-1:0];
   assign hit_raw  = (addr == A_RAW);
   assign hit_mset = (addr == A_MSET);
   assign hit_mclr = (addr == A_MCLR);
   assign hit_ptr  = (addr[ADDR_W-1:SLOT_W] == A_PTR[ADDR_W-1:SLOT_W]) &&
                     ({1'b0, slot} < (SLOT_W+1)'(NUM));

   for (genvar g = 0; g < NUM; g++) begin : g_chan
      cpirq_chan #(.PTR_W(PTR_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .hw_we   (upd_vld && (upd_chan == IDX_W'(g))),
         .hw_data (upd_ptr),
         .sw_we   (wr_en && hit_ptr && (slot == SLOT_W'(g))),
         .sw_data (wdata),
         .hw_ptr  (hw_ptrs[g]),
         .pending (raw[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  mask_q <= '0;
      else if (wr_en && hit_mset)  mask_q <= mask_q | wdata[NUM-1:0];
      else if (wr_en && hit_mclr)  mask_q <= mask_q & ~wdata[NUM-1:0];
   end

   assign mask = mask_q;
   assign irq  = |(raw & mask_q);

   always_comb begin
      rd_data = '0;
      if (hit_raw) rd_data[NUM-1:0] = raw;
      if (hit_mset || hit_mclr) rd_data[NUM-1:0] = mask_q;
      if (hit_ptr) begin
         for (int i = 0; i < NUM; i++) begin
            if (slot == SLOT_W'(i)) rd_data = hw_ptrs[i];
         end
      end
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_mset) |=> ((mask_q & $past(wdata[NUM-1:0])) == $past(wdata[NUM-1:0]))); // R6
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_mclr) |=> ((mask_q & $past(wdata[NUM-1:0])) == '0)); // R7
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (hit_mset || hit_mclr)) |=> $stable(mask_q)); // R11
endmodule

// File: rtl/cp_irq_unit.sv
module cp_irq_unit
   import cpirq_pkg::*;
#(
   parameter int unsigned NUM_TX = 8,
   parameter int unsigned NUM_RX = 8,
   parameter int unsigned PTR_W  = 32,
   localparam int unsigned TX_IDX_W = idx_width(NUM_TX),
   localparam int unsigned RX_IDX_W = idx_width(NUM_RX)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_upd_vld,
   input  logic [TX_IDX_W-1:0] tx_upd_chan,
   input  logic [PTR_W-1:0]    tx_upd_ptr,
   input  logic                rx_upd_vld,
   input  logic [RX_IDX_W-1:0] rx_upd_chan,
   input  logic [PTR_W-1:0]    rx_upd_ptr,
   input  logic                bus_wr_en,
   input  logic                bus_rd_en,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [PTR_W-1:0]    bus_wdata,
   output logic [PTR_W-1:0]    bus_rdata,
   output logic                tx_irq,
   output logic                rx_irq
);
   logic [NUM_TX-1:0] tx_raw, tx_mask;
   logic [NUM_RX-1:0] rx_raw, rx_mask;
   logic [PTR_W-1:0]  tx_rd, rx_rd;
   logic [PTR_W-1:0]  rdata_q;

   cpirq_bank #(
      .NUM(NUM_TX), .PTR_W(PTR_W), .A_RAW(ADR_TX_RAW),
      .A_MSET(ADR_TX_MSET), .A_MCLR(ADR_TX_MCLR), .A_PTR(ADR_TX_PTR)
   ) u_tx (
      .clk(clk), .rst_n(rst_n),
      .upd_vld(tx_upd_vld), .upd_chan(tx_upd_chan), .upd_ptr(tx_upd_ptr),
      .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
      .raw(tx_raw), .mask(tx_mask), .irq(tx_irq), .rd_data(tx_rd)
   );

   cpirq_bank #(
      .NUM(NUM_RX), .PTR_W(PTR_W), .A_RAW(ADR_RX_RAW),
      .A_MSET(ADR_RX_MSET), .A_MCLR(ADR_RX_MCLR), .A_PTR(ADR_RX_PTR)
   ) u_rx (
      .clk(clk), .rst_n(rst_n),
      .upd_vld(rx_upd_vld), .upd_chan(rx_upd_chan), .upd_ptr(rx_upd_ptr),
      .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
      .raw(rx_raw), .mask(rx_mask), .irq(rx_irq), .rd_data(rx_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         rdata_q <= '0;
      else if (bus_rd_en) rdata_q <= tx_rd | rx_rd;
   end

   assign bus_rdata = rdata_q;

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rdata)); // R11
   AST_TX_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> ((tx_raw & tx_mask) != '0)); // R10
   AST_RX_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> ((rx_raw & rx_mask) != '0)); // R10
endmodule

// File: tb/cp_irq_unit_tb.sv
`timescale 1ns/1ps
module cp_irq_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_upd_vld = 1'b0, rx_upd_vld = 1'b0;
   logic [2:0]  tx_upd_chan = '0, rx_upd_chan = '0;
   logic [31:0] tx_upd_ptr = '0, rx_upd_ptr = '0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_irq, rx_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] m_hw_tx [8];
   logic [31:0] m_sw_tx [8];
   logic [31:0] m_hw_rx [8];
   logic [31:0] m_sw_rx [8];
   logic [7:0]  m_mtx, m_mrx;

   always #4 clk = ~clk;

   cp_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .tx_upd_vld(tx_upd_vld), .tx_upd_chan(tx_upd_chan), .tx_upd_ptr(tx_upd_ptr),
      .rx_upd_vld(rx_upd_vld), .rx_upd_chan(rx_upd_chan), .rx_upd_ptr(rx_upd_ptr),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   function automatic logic [7:0] raw_tx();
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = (m_hw_tx[i] != m_sw_tx[i]);
      return r;
   endfunction

   function automatic logic [7:0] raw_rx();
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = (m_hw_rx[i] != m_sw_rx[i]);
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h02: m_mtx = m_mtx | d[7:0];
         8'h03: m_mtx = m_mtx & ~d[7:0];
         8'h04: m_mrx = m_mrx | d[7:0];
         8'h05: m_mrx = m_mrx & ~d[7:0];
         default: begin
            if (a[7:4] == 4'h1 && a[3:0] < 4'd8) m_sw_tx[a[2:0]] = d;
            if (a[7:4] == 4'h2 && a[3:0] < 4'd8) m_sw_rx[a[2:0]] = d;
         end
      endcase
   endtask

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00: return {24'd0, raw_tx()};
         8'h01: return {24'd0, raw_rx()};
         8'h02, 8'h03: return {24'd0, m_mtx};
         8'h04, 8'h05: return {24'd0, m_mrx};
         default: begin
            if (a[7:4] == 4'h1 && a[3:0] < 4'd8) return m_hw_tx[a[2:0]];
            if (a[7:4] == 4'h2 && a[3:0] < 4'd8) return m_hw_rx[a[2:0]];
            return 32'd0;
         end
      endcase
   endfunction

   // called at a negedge; returns at the following negedge
   task automatic step(input bit tu, input logic [2:0] tc, input logic [31:0] tp,
                       input bit ru, input logic [2:0] rc, input logic [31:0] rp,
                       input bit we, input logic [7:0] wa, input logic [31:0] wd);
      tx_upd_vld = tu; tx_upd_chan = tc; tx_upd_ptr = tp;
      rx_upd_vld = ru; rx_upd_chan = rc; rx_upd_ptr = rp;
      bus_wr_en = we; bus_addr = wa; bus_wdata = wd;
      @(posedge clk);
      if (tu) m_hw_tx[tc] = tp;
      if (ru) m_hw_rx[rc] = rp;
      if (we) model_write(wa, wd);
      @(negedge clk);
      tx_upd_vld = 1'b0; rx_upd_vld = 1'b0; bus_wr_en = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      step(1'b0, 3'd0, 32'd0, 1'b0, 3'd0, 32'd0, 1'b1, a, d);
   endtask

   task automatic rd_check(input logic [7:0] a, input string tag);
      logic [31:0] exp;
      exp = model_read(a);
      bus_rd_en = 1'b1; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_rd_en = 1'b0;
      check(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   task automatic irq_check(input string tag);
      logic [7:0] et, er;
      et = raw_tx() & m_mtx;
      er = raw_rx() & m_mrx;
      check(tx_irq == (|et), {tag, " tx_irq"}, {31'd0, tx_irq}, {31'd0, |et});
      check(rx_irq == (|er), {tag, " rx_irq"}, {31'd0, rx_irq}, {31'd0, |er});
   endtask

   initial begin
      int unsigned seed_val;
      for (int i = 0; i < 8; i++) begin
         m_hw_tx[i] = '0; m_sw_tx[i] = '0; m_hw_rx[i] = '0; m_sw_rx[i] = '0;
      end
      m_mtx = '0; m_mrx = '0;
      seed_val = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      check(tx_irq == 1'b0 && rx_irq == 1'b0, "R9 irqs low after reset", {30'd0, tx_irq, rx_irq}, 32'd0);
      rd_check(8'h00, "R9 tx raw after reset");
      rd_check(8'h01, "R9 rx raw after reset");
      rd_check(8'h13, "R9 tx pointer after reset");
      rd_check(8'h02, "R9 tx enables after reset");

      // R2 R4 R5: hardware completion raises raw status, masked output stays low
      step(1'b1, 3'd3, 32'h100, 1'b0, 3'd0, 32'd0, 1'b0, 8'h00, 32'd0);
      rd_check(8'h00, "R5 tx raw bit 3 pending");
      rd_check(8'h13, "R2 tx pointer 3 readback");
      irq_check("R10 masked off");
      // R6: enable channel 3
      wr(8'h02, 32'h0000_0008);
      rd_check(8'h02, "R6 tx enable set");
      irq_check("R10 enabled pending");
      // R3 R4: mismatching acknowledge keeps pending; readback is hardware value
      wr(8'h13, 32'h0FF);
      rd_check(8'h13, "R3 pointer read ignores sw write");
      irq_check("R4 mismatched ack");
      // R4: matching acknowledge clears
      wr(8'h13, 32'h100);
      rd_check(8'h00, "R4 matching ack clears");
      irq_check("R4 after ack");
      // R8: simultaneous update and ack to same value
      step(1'b1, 3'd3, 32'h200, 1'b0, 3'd0, 32'd0, 1'b1, 8'h13, 32'h200);
      rd_check(8'h00, "R8 same-cycle update and ack");
      // R8: simultaneous with differing values stays pending
      step(1'b1, 3'd3, 32'h300, 1'b0, 3'd0, 32'd0, 1'b1, 8'h13, 32'h200);
      rd_check(8'h00, "R8 same-cycle update beats stale ack");
      irq_check("R8 stale ack");
      // R7: clear enable with a write-0 neighbour unchanged
      wr(8'h02, 32'h0000_0011);
      wr(8'h03, 32'h0000_0008);
      rd_check(8'h03, "R7 tx enable clear");
      irq_check("R7 after clear");
      // R1: receive channel 7 at 0x27
      step(1'b0, 3'd0, 32'd0, 1'b1, 3'd7, 32'hABCD, 1'b0, 8'h00, 32'd0);
      rd_check(8'h27, "R1 rx pointer 7 address");
      rd_check(8'h01, "R1 rx raw bit 7");
      wr(8'h04, 32'h0000_0080);
      irq_check("R1 rx channel 7 enabled");
      // R11: writes to status and unmapped addresses ignored, unmapped reads zero
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h18, 32'h1234);
      wr(8'h40, 32'hFFFF_FFFF);
      rd_check(8'h00, "R11 raw status not writable");
      rd_check(8'h40, "R11 unmapped reads zero");
      rd_check(8'h02, "R11 enables untouched");

      // random phase
      for (int it = 0; it < 3000; it++) begin
         bit          tu, ru, we;
         logic [2:0]  tc, rc;
         logic [31:0] tp, rp, wd;
         logic [7:0]  wa;
         int unsigned op;
         tu = $urandom_range(1, 0) == 1;
         ru = $urandom_range(1, 0) == 1;
         tc = 3'($urandom_range(7, 0));
         rc = 3'($urandom_range(7, 0));
         tp = 32'($urandom_range(7, 0));
         rp = 32'($urandom_range(7, 0));
         op = $urandom_range(9, 0);
         we = 1'b1;
         wd = 32'($urandom_range(255, 0));
         case (op)
            0, 1, 2: begin
               wa = {5'b00010, 3'($urandom_range(7, 0))};
               wd = ($urandom_range(1, 0) == 1) ? m_hw_tx[wa[2:0]] : 32'($urandom_range(7, 0));
            end
            3, 4, 5: begin
               wa = {5'b00100, 3'($urandom_range(7, 0))};
               wd = ($urandom_range(1, 0) == 1) ? m_hw_rx[wa[2:0]] : 32'($urandom_range(7, 0));
            end
            6: wa = 8'h02 + 8'($urandom_range(3, 0));
            default: begin we = 1'b0; wa = 8'h00; end
         endcase
         step(tu, tc, tp, ru, rc, rp, we, wa, wd);
         irq_check("R10 random");
         if (it % 64 == 0) begin
            rd_check(8'h00, "R5 random tx raw");
            rd_check(8'h01, "R5 random rx raw");
            rd_check({5'b00010, 3'($urandom_range(7, 0))}, "R2 random tx pointer");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule